// File: doc/BRIEF.md
# Serial Flash Erase Command Front End

This block is the slave-side command decoder of a serial NOR flash. It handles four instructions: enable writes, read status, erase the whole array and erase one sector. It oversamples the serial clock, the active-low select and the single data input with the system clock. It keeps an 8-bit status byte that holds a busy flag, a write-enable latch and four protection bits. The protection bits come from the part's nonvolatile configuration on `bp_cfg`.

An erase is accepted only when all of the following hold: select rises exactly on the required bit boundary, the write-enable latch is set, every protection bit is zero and no erase is already running. When an erase is accepted, the block pulses `er_stb` for one cycle, together with either the whole-array flag or the sector address. It then runs a self-timed busy period of `ERASE_CYCLES` system clocks. Data is sampled on rising serial clock edges and status is shifted out on falling edges, most significant bit first. The serial clock idles low.

Top module: `fl_erase_front`

## Requirements
- R1: After reset, the status byte reads 00h when `bp_cfg` is zero, `er_stb` is low and `spi_miso` is 0.
- R2: Opcode 06h, followed by select rising after exactly 8 clocks, sets the write-enable latch (status bit 1).
- R3: An 06h frame that ends after any count other than 8 clocks leaves the write-enable latch unchanged.
- R4: Opcode 05h returns the status byte on `spi_miso`, MSB first, starting at the falling edge after the 8th clock. The byte repeats for as long as clocks continue. Its layout is: bit 0 busy, bit 1 write-enable latch, bits 5:2 `bp_cfg[3:0]`, bits 7:6 zero. `spi_miso` is 0 while select is high.
- R5: Opcode C7h in a frame of exactly 8 clocks, with the latch set and `bp_cfg` zero, gives one `er_stb` pulse with `er_whole`=1.
- R6: A C7h frame of any other length gives no erase and leaves the latch set.
- R7: An erase opcode is ignored when the write-enable latch is clear.
- R8: An erase opcode is ignored while any `bp_cfg` bit is 1. The latch stays set.
- R9: Opcode D8h, followed by a 24-bit address MSB first in a frame of exactly 32 clocks, gives one `er_stb` pulse with `er_whole`=0 and `er_addr` equal to that address. Any other length gives no erase.
- R10: Accepting an erase clears the write-enable latch in the same cycle and raises the busy bit for `ERASE_CYCLES` clocks. The busy bit then returns to 0.
- R11: While busy is 1, every instruction except 05h is ignored, including 06h and both erase opcodes.
- R12: An 8-clock frame with an opcode other than the four above changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock, idle low |
| spi_cs_n | input | 1 | Active-low select |
| spi_mosi | input | 1 | Serial data in |
| bp_cfg | input | 4 | Block-protection bits from nonvolatile configuration |
| spi_miso | output | 1 | Serial status data out |
| er_stb | output | 1 | One-cycle erase request |
| er_whole | output | 1 | 1 for a whole-array erase, 0 for a sector erase |
| er_addr | output | ADDR_BITS | Sector address of the last accepted erase (0 for a whole-array erase) |

## Verification
Every serial edge takes `SYNC_STAGES` clocks to synchronise, plus one edge-detect register, before any state moves. The erase strobe and the busy start therefore land `SYNC_STAGES`+1 clocks after select rises, and a new status bit appears on `spi_miso` the same number of clocks after a falling serial edge. The bench holds every serial half period for six system clocks and samples `spi_miso` only just before the next rising edge. After select rises it waits twelve clocks before it judges anything. The erase strobe is caught by a negative-edge monitor that counts pulses and latches the flag and address, so the checks do not depend on the exact cycle of the one-cycle pulse. The busy period is probed by a status read well inside `ERASE_CYCLES` and again after waiting past it.

// File: rtl/fl_erase_pkg.sv
package fl_erase_pkg;
   localparam logic [7:0] OPC_WEN   = 8'h06;
   localparam logic [7:0] OPC_STAT  = 8'h05;
   localparam logic [7:0] OPC_WHOLE = 8'hC7;
   localparam logic [7:0] OPC_SECT  = 8'hD8;

   localparam int OPC_BITS   = 8;
   localparam int PROT_BITS  = 4;
   localparam int STAT_BITS  = 8;
   localparam int ST_BUSY    = 0;
   localparam int ST_LATCH   = 1;
   localparam int ST_PROT_LO = 2;

   typedef enum logic [1:0] {
      ACT_NONE  = 2'd0,
      ACT_WEN   = 2'd1,
      ACT_WHOLE = 2'd2,
      ACT_SECT  = 2'd3
   } act_e;
endpackage

// File: rtl/fl_edge_sync.sv
module fl_edge_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic lvl,
   output logic rise,
   output logic fall
);
   logic [STAGES-1:0] chain;
   logic              prev;

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("fl_edge_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= RST_VAL;
               else        chain[0] <= din;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= RST_VAL;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= RST_VAL;
      else        prev <= lvl;
   end

   assign lvl  = chain[STAGES-1];
   assign rise = lvl & ~prev;
   assign fall = ~lvl & prev;
endmodule

// File: rtl/fl_cmd_shift.sv
module fl_cmd_shift
   import fl_erase_pkg::*;
#(
   parameter int FRAME_BITS = 32,
   parameter int CNT_W      = 6
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  sck_rise,
   input  logic                  sel_low,
   input  logic                  sel_fall,
   input  logic                  mosi,
   output logic [FRAME_BITS-1:0] shreg,
   output logic [CNT_W-1:0]      nbits,
   output logic                  stat_hit
);
   localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] OPC_LAST = CNT_W'(OPC_BITS - 1);

   generate
      if (FRAME_BITS < OPC_BITS + 1) begin : g_bad_frame
         $error("fl_cmd_shift: frame must be longer than one opcode");
      end
      if ((2 ** CNT_W) <= FRAME_BITS + 1) begin : g_bad_cnt
         $error("fl_cmd_shift: counter too narrow for the frame");
      end
   endgenerate

   logic [OPC_BITS-1:0] next_byte;
   assign next_byte = {shreg[OPC_BITS-2:0], mosi};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg <= '0;
         nbits <= '0;
      end else if (sel_fall) begin
         shreg <= '0;
         nbits <= '0;
      end else if (sel_low && sck_rise) begin
         shreg <= {shreg[FRAME_BITS-2:0], mosi};
         if (nbits != CNT_MAX) nbits <= nbits + 1'b1;
      end
   end

   assign stat_hit = sel_low && sck_rise && (nbits == OPC_LAST) && (next_byte == OPC_STAT);

   p_frame_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      sel_fall |=> (nbits == '0));
endmodule

// File: rtl/fl_stat_tx.sv
module fl_stat_tx
   import fl_erase_pkg::*;
#(
   parameter bit REPEAT = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic                 sck_fall,
   input  logic                 sel_high,
   input  logic [STAT_BITS-1:0] status,
   output logic                 miso
);
   localparam int IW = $clog2(STAT_BITS);

   logic                 on_q;
   logic [IW-1:0]        idx;
   logic [STAT_BITS-1:0] snap;
   logic                 stop_at_wrap;

   generate
      if (REPEAT) begin : g_repeat
         assign stop_at_wrap = 1'b0;
      end else begin : g_once
         assign stop_at_wrap = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         on_q <= 1'b0;
         idx  <= IW'(STAT_BITS - 1);
         snap <= '0;
         miso <= 1'b0;
      end else if (sel_high) begin
         on_q <= 1'b0;
         idx  <= IW'(STAT_BITS - 1);
         miso <= 1'b0;
      end else if (start) begin
         on_q <= 1'b1;
         idx  <= IW'(STAT_BITS - 1);
      end else if (sck_fall) begin
         if (on_q) begin
            if (idx == IW'(STAT_BITS - 1)) begin
               snap <= status;
               miso <= status[STAT_BITS-1];
            end else begin
               miso <= snap[idx];
            end
            idx <= idx - 1'b1;
            if (idx == '0 && stop_at_wrap) on_q <= 1'b0;
         end else begin
            miso <= 1'b0;
         end
      end
   end

   p_miso_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      sel_high |=> !miso);
endmodule

// File: rtl/fl_erase_timer.sv
module fl_erase_timer #(
   parameter int CYCLES = 1000,
   parameter int CW     = $clog2(CYCLES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   localparam logic [CW-1:0] LOAD = CW'(CYCLES);

   generate
      if (CYCLES < 1) begin : g_bad_len
         $error("fl_erase_timer: CYCLES must be at least 1");
      end
   endgenerate

   logic [CW-1:0] left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          left <= '0;
      else if (start)      left <= LOAD;
      else if (left != '0) left <= left - 1'b1;
   end

   assign busy = (left != '0);

   p_start_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy);
   p_busy_follows_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy);
endmodule

// File: rtl/fl_erase_front.sv
module fl_erase_front
   import fl_erase_pkg::*;
#(
   parameter int ADDR_BITS    = 24,
   parameter int ERASE_CYCLES = 1000,
   parameter int SYNC_STAGES  = 2,
   parameter bit STAT_REPEAT  = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 spi_sck,
   input  logic                 spi_cs_n,
   input  logic                 spi_mosi,
   input  logic [PROT_BITS-1:0] bp_cfg,
   output logic                 spi_miso,
   output logic                 er_stb,
   output logic                 er_whole,
   output logic [ADDR_BITS-1:0] er_addr
);
   localparam int               FRAME_BITS = OPC_BITS + ADDR_BITS;
   localparam int               CNT_W      = $clog2(FRAME_BITS + 2);
   localparam logic [CNT_W-1:0] LEN_OPC    = CNT_W'(OPC_BITS);
   localparam logic [CNT_W-1:0] LEN_SECT   = CNT_W'(FRAME_BITS);

   generate
      if (ADDR_BITS < 1 || ADDR_BITS > 48) begin : g_bad_addr
         $error("fl_erase_front: ADDR_BITS out of range");
      end
   endgenerate

   logic sck_lvl, sck_rise, sck_fall;
   logic cs_lvl, cs_rise, cs_fall;
   logic mosi_lvl, mosi_r_unused, mosi_f_unused;

   fl_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sck (
      .clk(clk), .rst_n(rst_n), .din(spi_sck),
      .lvl(sck_lvl), .rise(sck_rise), .fall(sck_fall));
   fl_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs (
      .clk(clk), .rst_n(rst_n), .din(spi_cs_n),
      .lvl(cs_lvl), .rise(cs_rise), .fall(cs_fall));
   fl_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_mosi (
      .clk(clk), .rst_n(rst_n), .din(spi_mosi),
      .lvl(mosi_lvl), .rise(mosi_r_unused), .fall(mosi_f_unused));

   logic                  sel_low;
   logic [FRAME_BITS-1:0] shreg;
   logic [CNT_W-1:0]      nbits;
   logic                  stat_hit;

   assign sel_low = ~cs_lvl;

   fl_cmd_shift #(.FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .sck_rise(sck_rise), .sel_low(sel_low),
      .sel_fall(cs_fall), .mosi(mosi_lvl), .shreg(shreg), .nbits(nbits),
      .stat_hit(stat_hit));

   // Status byte and latch
   logic                 wel_q;
   logic                 busy;
   logic [STAT_BITS-1:0] status;

   always_comb begin
      status                                 = '0;
      status[ST_BUSY]                        = busy;
      status[ST_LATCH]                       = wel_q;
      status[ST_PROT_LO +: PROT_BITS]        = bp_cfg;
   end

   fl_stat_tx #(.REPEAT(STAT_REPEAT)) u_tx (
      .clk(clk), .rst_n(rst_n), .start(stat_hit), .sck_fall(sck_fall),
      .sel_high(cs_lvl), .status(status), .miso(spi_miso));

   // Frame decode at select rise
   act_e act;
   logic guard_ok;

   assign guard_ok = wel_q && (bp_cfg == '0);

   always_comb begin
      act = ACT_NONE;
      if (cs_rise && !busy) begin
         if (nbits == LEN_OPC && shreg[OPC_BITS-1:0] == OPC_WEN)
            act = ACT_WEN;
         else if (nbits == LEN_OPC && shreg[OPC_BITS-1:0] == OPC_WHOLE && guard_ok)
            act = ACT_WHOLE;
         else if (nbits == LEN_SECT && shreg[FRAME_BITS-1 -: OPC_BITS] == OPC_SECT && guard_ok)
            act = ACT_SECT;
      end
   end

   logic go_erase;
   assign go_erase = (act == ACT_WHOLE) || (act == ACT_SECT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wel_q    <= 1'b0;
         er_stb   <= 1'b0;
         er_whole <= 1'b0;
         er_addr  <= '0;
      end else begin
         er_stb <= 1'b0;
         if (go_erase) begin
            er_stb   <= 1'b1;
            er_whole <= (act == ACT_WHOLE);
            er_addr  <= (act == ACT_WHOLE) ? '0 : shreg[ADDR_BITS-1:0];
            wel_q    <= 1'b0;
         end else if (act == ACT_WEN) begin
            wel_q <= 1'b1;
         end
      end
   end

   fl_erase_timer #(.CYCLES(ERASE_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n), .start(go_erase), .busy(busy));

   p_req_needs_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
      er_stb |-> $past(wel_q));
   p_req_unprotected_r8: assert property (@(posedge clk) disable iff (!rst_n)
      er_stb |-> ($past(bp_cfg) == '0));
   p_req_busy_nolatch_r10: assert property (@(posedge clk) disable iff (!rst_n)
      er_stb |-> (busy && !wel_q));
   p_req_not_when_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
      er_stb |-> !$past(busy));
   p_latch_low_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !wel_q);
endmodule

// File: tb/sim_fl_erase_front.sv
module sim_fl_erase_front;
   localparam int CLK_NS = 10;
   localparam int HALF   = 6;
   localparam int ECYC   = 600;
   localparam int AW     = 24;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sck = 1'b0;
   logic          cs_n = 1'b1;
   logic          mosi = 1'b0;
   logic [3:0]    bp = 4'h0;
   logic          miso, stb, whole;
   logic [AW-1:0] addr;

   int vec = 0;
   int bad = 0;
   int n_req = 0;
   logic          got_whole = 1'b0;
   logic [AW-1:0] got_addr = '0;
   bit finished = 1'b0;

   always #(CLK_NS/2) clk = ~clk;

   fl_erase_front #(.ADDR_BITS(AW), .ERASE_CYCLES(ECYC)) u0 (
      .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n),
      .spi_mosi(mosi), .bp_cfg(bp), .spi_miso(miso), .er_stb(stb),
      .er_whole(whole), .er_addr(addr));

   always @(negedge clk) if (stb) begin
      n_req++;
      got_whole = whole;
      got_addr  = addr;
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      vec++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic xfer(input logic [39:0] word, input int nb, output logic [39:0] rx);
      rx = '0;
      cs_n = 1'b0;
      repeat (HALF) @(negedge clk);
      for (int i = 0; i < nb; i++) begin
         mosi = word[39-i];
         repeat (HALF) @(negedge clk);
         rx = {rx[38:0], miso};
         sck = 1'b1;
         repeat (HALF) @(negedge clk);
         sck = 1'b0;
      end
      repeat (HALF) @(negedge clk);
      cs_n = 1'b1;
      mosi = 1'b0;
      repeat (12) @(negedge clk);
   endtask

   task automatic cmd(input logic [7:0] op, input int nb);
      logic [39:0] rx;
      xfer({op, 32'h0}, nb, rx);
   endtask

   task automatic rd_stat(output logic [7:0] s0, output logic [7:0] s1);
      logic [39:0] rx;
      xfer({8'h05, 32'h0}, 24, rx);
      s0 = rx[15:8];
      s1 = rx[7:0];
   endtask

   task automatic t_reset();
      logic [7:0] s0, s1;
      chk("R1 stb idle", {31'h0, stb}, 32'h0);
      chk("R1 miso idle", {31'h0, miso}, 32'h0);
      rd_stat(s0, s1);
      chk("R1 status after reset", {24'h0, s0}, 32'h00);
   endtask

   task automatic t_no_latch();
      logic [7:0] s0, s1;
      int n0 = n_req;
      cmd(8'hC7, 8);
      chk("R7 whole erase without latch", n_req, n0);
      rd_stat(s0, s1);
      chk("R7 status unchanged", {24'h0, s0}, 32'h00);
   endtask

   task automatic t_wen();
      logic [7:0] s0, s1;
      cmd(8'h06, 7);
      rd_stat(s0, s1);
      chk("R3 wen 7 clocks", {24'h0, s0}, 32'h00);
      cmd(8'h06, 9);
      rd_stat(s0, s1);
      chk("R3 wen 9 clocks", {24'h0, s0}, 32'h00);
      cmd(8'h06, 8);
      rd_stat(s0, s1);
      chk("R2 wen sets latch", {24'h0, s0}, 32'h02);
      chk("R4 status repeats", {24'h0, s1}, 32'h02);
      chk("R4 miso low after frame", {31'h0, miso}, 32'h0);
   endtask

   task automatic t_prot();
      logic [7:0] s0, s1;
      int n0 = n_req;
      bp = 4'b0100;
      cmd(8'hC7, 8);
      chk("R8 protected whole erase", n_req, n0);
      rd_stat(s0, s1);
      chk("R8 R4 status with protect", {24'h0, s0}, 32'h12);
      bp = 4'b1000;
      cmd(8'hC7, 8);
      chk("R8 protected top bit", n_req, n0);
      bp = 4'h0;
   endtask

   task automatic t_bad_len();
      logic [7:0] s0, s1;
      int n0 = n_req;
      cmd(8'hC7, 9);
      chk("R6 whole erase 9 clocks", n_req, n0);
      cmd(8'hC7, 16);
      chk("R6 whole erase 16 clocks", n_req, n0);
      cmd(8'hAB, 8);
      rd_stat(s0, s1);
      chk("R6 R12 latch kept", {24'h0, s0}, 32'h02);
   endtask

   task automatic t_whole();
      logic [7:0] s0, s1;
      int n0 = n_req;
      cmd(8'hC7, 8);
      chk("R5 one strobe", n_req, n0 + 1);
      chk("R5 whole flag", {31'h0, got_whole}, 32'h1);
      rd_stat(s0, s1);
      chk("R10 busy set latch cleared", {24'h0, s0}, 32'h01);
      cmd(8'h06, 8);
      repeat (ECYC) @(negedge clk);
      rd_stat(s0, s1);
      chk("R10 R11 idle after cycle, latch still clear", {24'h0, s0}, 32'h00);
   endtask

   task automatic t_sector();
      logic [7:0] s0, s1;
      logic [39:0] rx;
      int n0;
      cmd(8'h06, 8);
      n0 = n_req;
      xfer({8'hD8, 24'h5A3C81, 8'h0}, 31, rx);
      chk("R9 sector 31 clocks", n_req, n0);
      xfer({8'hD8, 24'h5A3C81, 8'h0}, 32, rx);
      chk("R9 sector strobe", n_req, n0 + 1);
      chk("R9 sector flag", {31'h0, got_whole}, 32'h0);
      chk("R9 sector addr", {8'h0, got_addr}, 32'h5A3C81);
      xfer({8'hD8, 24'h000123, 8'h0}, 32, rx);
      chk("R11 sector while busy", n_req, n0 + 1);
      repeat (ECYC) @(negedge clk);
      rd_stat(s0, s1);
      chk("R10 idle after sector", {24'h0, s0}, 32'h00);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         bad++;
         vec++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      t_reset();
      t_no_latch();
      t_wen();
      t_prot();
      t_bad_len();
      t_whole();
      t_sector();
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
   end
endmodule